// File: doc/BRIEF.md
# DMA Unit Transfer Engine

This block moves one block of data for whichever channel the arbiter has made active. A start pulse hands over the channel's settings: pointers, unit count, unit width (16 or 32 bits), pointer modes, repeat, timing mode and interrupt enable. The engine then runs the block one unit at a time. For each unit it reads the source and writes the destination over a request/ready memory port, with the two accesses in separate phases. Each unit is charged a cycle cost taken from wait-state tables indexed by memory region.

One 32-bit holding register sits between the read and the write. A zero source pointer suppresses the read, so the held value is written again. A 16-bit read is mirrored into both halves of the holding register. When the last unit is done, the engine reports block completion. It also tells the front-end whether to drop the channel's enable, raises the interrupt pulse if it is enabled, and leaves the final pointers on its outputs. In the reload mode this final destination is the starting destination.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the engine is idle: no memory request, no done, interrupt or clear pulses, both pointer outputs zero, and the holding register zero, so a zero-source block written first stores 0.
- R2: The 2-bit pointer modes step the pointer once per unit: 0 adds the unit width (2 or 4), 1 subtracts it, 2 holds it, and 3 adds it. Unit i writes to the destination pointer as stepped i times.
- R3: With an always-ready port, each unit lasts 2 + ws(src region) + ws(dst region) cycles. Region is address bits [27:24]. The entry for (seq, wide, region) sits at ws_tbl_i bits [((seq*2+wide)*16+region)*4 +: 4]. The first unit of a block uses seq=0 and later units use seq=1. blk_done_o rises that many summed cycles after the start edge, plus R8.
- R4: With a zero source pointer the engine issues no read, writes the held value, and leaves the source pointer at zero.
- R5: A 16-bit read places bits [15:0] of the read data into both halves of the holding register, and the write data carries all 32 bits.
- R6: en_clr_o pulses with blk_done_o when repeat is off, or timing mode is 0 (immediate), or the channel is 3 with timing mode 3 while last_line_i is high.
- R7: irq_o pulses with blk_done_o exactly when the interrupt enable was set. In dst mode 3, dst_o shows the aligned starting destination at block end.
- R8: If the source or destination region of the last unit is below 8, two extra cycles pass before blk_done_o.
- R9: unit_done_o pulses once per unit and blk_done_o is high for exactly one cycle per block.
- R10: At start both pointers are aligned to the unit width: bit 0 is cleared for 16-bit units, and bits [1:0] for 32-bit units.
- R11: A request holds its address and direction until mem_ready_i. Stalls change only the timing, never the data or the addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a block (taken while idle) |
| chan_i | input | 2 | Active channel number |
| src_i | input | 28 | Source pointer |
| dst_i | input | 28 | Destination pointer |
| count_i | input | 17 | Unit count (nonzero) |
| wide_i | input | 1 | 1 = 32-bit units, 0 = 16-bit |
| src_mode_i | input | 2 | Source pointer mode |
| dst_mode_i | input | 2 | Destination pointer mode |
| repeat_i | input | 1 | Channel repeat setting |
| timing_i | input | 2 | Timing mode of the channel |
| irq_en_i | input | 1 | Interrupt enable |
| last_line_i | input | 1 | Display is on the line after the visible area |
| ws_tbl_i | input | 256 | Packed wait-state tables |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write phase |
| mem_wide_o | output | 1 | Access size, 1 = 32-bit |
| mem_addr_o | output | 28 | Access address |
| mem_wdata_o | output | 32 | Write data (holding register) |
| mem_rdata_i | input | 32 | Read data |
| mem_ready_i | input | 1 | Access completes this cycle |
| busy_o | output | 1 | Block in progress |
| unit_done_o | output | 1 | One unit finished |
| blk_done_o | output | 1 | Block finished |
| irq_o | output | 1 | Channel interrupt pulse |
| en_clr_o | output | 1 | Drop the channel enable |
| src_o | output | 28 | Current source pointer |
| dst_o | output | 28 | Current destination pointer |

## Verification
Block completion is due a fixed number of cycles after the start edge. That number is the per-unit costs from the tables plus the two tail cycles, so the bench counts falling edges from the start edge and compares the count at the falling edge where blk_done_o is first seen. The interrupt, clear and pointer outputs are read at that same falling edge. Unit pulses and captured writes are compared one falling edge later, once the last unit pulse has been registered, and blk_done_o is required to be low there. Blocks with random ready stalls skip the cycle count and keep the data and address checks.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [1:0] {
    STEP_INC     = 2'd0,
    STEP_DEC     = 2'd1,
    STEP_FIX     = 2'd2,
    STEP_INC_RLD = 2'd3
  } step_mode_e;

  typedef enum logic [1:0] {
    TIM_NOW     = 2'd0,
    TIM_VBL     = 2'd1,
    TIM_HBL     = 2'd2,
    TIM_SPECIAL = 2'd3
  } timing_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_WR, S_WAIT, S_TAIL, S_FIN
  } xfer_state_e;
endpackage

// File: rtl/dma_xfer_step.sv
module dma_xfer_step
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W      = 28,
  parameter bit FREEZE_ZERO = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        mode_i,
  input  logic              wide_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] step_w;
  assign step_w = wide_i ? ADDR_W'(4) : ADDR_W'(2);

  always_comb begin
    unique case (step_mode_e'(mode_i))
      STEP_DEC: next_o = addr_i - step_w;
      STEP_FIX: next_o = addr_i;
      default:  next_o = addr_i + step_w;
    endcase
    if (FREEZE_ZERO && addr_i == '0) next_o = addr_i;
  end
endmodule

// File: rtl/dma_xfer_cost.sv
module dma_xfer_cost #(
  parameter int REG_W = 4,
  parameter int WS_W  = 4,
  localparam int NREG  = 1 << REG_W,
  localparam int TBL_W = 4 * NREG * WS_W,
  localparam int CYC_W = WS_W + 2
) (
  input  logic [TBL_W-1:0] tbl_i,
  input  logic [REG_W-1:0] src_reg_i,
  input  logic [REG_W-1:0] dst_reg_i,
  input  logic             seq_i,
  input  logic             wide_i,
  output logic [CYC_W-1:0] cost_o
);
  localparam int IDX_W = REG_W + 2;
  logic [IDX_W-1:0] idx_s, idx_d;
  logic [WS_W-1:0]  ws_s, ws_d;

  assign idx_s = {seq_i, wide_i, src_reg_i};
  assign idx_d = {seq_i, wide_i, dst_reg_i};
  assign ws_s  = tbl_i[int'(idx_s)*WS_W +: WS_W];
  assign ws_d  = tbl_i[int'(idx_d)*WS_W +: WS_W];
  assign cost_o = CYC_W'(2) + CYC_W'(ws_s) + CYC_W'(ws_d);
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W     = 28,
  parameter int CNT_W      = 17,
  parameter int REG_W      = 4,
  parameter int WS_W       = 4,
  parameter int LOW_REGION = 8,
  localparam int NREG  = 1 << REG_W,
  localparam int TBL_W = 4 * NREG * WS_W,
  localparam int CYC_W = WS_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        chan_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wide_i,
  input  logic [1:0]        src_mode_i,
  input  logic [1:0]        dst_mode_i,
  input  logic              repeat_i,
  input  logic [1:0]        timing_i,
  input  logic              irq_en_i,
  input  logic              last_line_i,
  input  logic [TBL_W-1:0]  ws_tbl_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_wide_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              busy_o,
  output logic              unit_done_o,
  output logic              blk_done_o,
  output logic              irq_o,
  output logic              en_clr_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o
);
  xfer_state_e       state_q;
  logic [ADDR_W-1:0] src_q, dst_q, dst_base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CYC_W-1:0]  t_q, t_inc, cost;
  logic [31:0]       hold_q;
  logic              first_q, wide_q, rep_q, irq_en_q, unit_done_q;
  logic [1:0]        chan_q, smode_q, dmode_q, tim_q;
  logic              cost_met, unit_end, low_region;
  logic [ADDR_W-1:0] src_al, dst_al;

  // pointer steppers: index 0 = source (frozen at zero), 1 = destination
  logic [ADDR_W-1:0] ptr   [2];
  logic [ADDR_W-1:0] ptr_n [2];
  logic [1:0]        pmode [2];
  assign ptr[0]   = src_q;
  assign ptr[1]   = dst_q;
  assign pmode[0] = smode_q;
  assign pmode[1] = dmode_q;

  for (genvar g = 0; g < 2; g++) begin : g_step
    dma_xfer_step #(.ADDR_W(ADDR_W), .FREEZE_ZERO(g == 0)) u_step (
      .addr_i (ptr[g]),
      .mode_i (pmode[g]),
      .wide_i (wide_q),
      .next_o (ptr_n[g])
    );
  end

  dma_xfer_cost #(.REG_W(REG_W), .WS_W(WS_W)) u_cost (
    .tbl_i     (ws_tbl_i),
    .src_reg_i (src_q[ADDR_W-1 -: REG_W]),
    .dst_reg_i (dst_q[ADDR_W-1 -: REG_W]),
    .seq_i     (~first_q),
    .wide_i    (wide_q),
    .cost_o    (cost)
  );

  assign src_al = {src_i[ADDR_W-1:2], src_i[1] & ~wide_i, 1'b0};
  assign dst_al = {dst_i[ADDR_W-1:2], dst_i[1] & ~wide_i, 1'b0};

  assign t_inc      = (t_q == '1) ? t_q : t_q + 1'b1;
  assign cost_met   = t_q >= cost - 1'b1;
  assign unit_end   = (state_q == S_WR && mem_ready_i && cost_met) ||
                      (state_q == S_WAIT && cost_met);
  assign low_region = (int'(src_q[ADDR_W-1 -: REG_W]) < LOW_REGION) ||
                      (int'(dst_q[ADDR_W-1 -: REG_W]) < LOW_REGION);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      src_q       <= '0;
      dst_q       <= '0;
      dst_base_q  <= '0;
      cnt_q       <= '0;
      t_q         <= '0;
      hold_q      <= '0;
      first_q     <= 1'b0;
      wide_q      <= 1'b0;
      rep_q       <= 1'b0;
      irq_en_q    <= 1'b0;
      chan_q      <= '0;
      smode_q     <= '0;
      dmode_q     <= '0;
      tim_q       <= '0;
      unit_done_q <= 1'b0;
    end else begin
      unit_done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          src_q      <= src_al;
          dst_q      <= dst_al;
          dst_base_q <= dst_al;
          cnt_q      <= count_i;
          wide_q     <= wide_i;
          smode_q    <= src_mode_i;
          dmode_q    <= dst_mode_i;
          rep_q      <= repeat_i;
          tim_q      <= timing_i;
          chan_q     <= chan_i;
          irq_en_q   <= irq_en_i;
          first_q    <= 1'b1;
          t_q        <= '0;
          state_q    <= (src_al != '0) ? S_RD : S_WR;
        end
        S_RD: begin
          t_q <= t_inc;
          if (mem_ready_i) begin
            hold_q  <= wide_q ? mem_rdata_i : {2{mem_rdata_i[15:0]}};
            state_q <= S_WR;
          end
        end
        S_WR: begin
          t_q <= t_inc;
          if (mem_ready_i) state_q <= S_WAIT;
        end
        S_WAIT: t_q <= t_inc;
        S_TAIL: begin
          t_q <= t_inc;
          if (t_q == CYC_W'(1)) state_q <= S_FIN;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase

      if (unit_end) begin
        unit_done_q <= 1'b1;
        first_q     <= 1'b0;
        t_q         <= '0;
        cnt_q       <= cnt_q - 1'b1;
        src_q       <= ptr_n[0];
        if (cnt_q == CNT_W'(1)) begin
          dst_q   <= (step_mode_e'(dmode_q) == STEP_INC_RLD) ? dst_base_q : ptr_n[1];
          state_q <= low_region ? S_TAIL : S_FIN;
        end else begin
          dst_q   <= ptr_n[1];
          state_q <= (ptr_n[0] != '0) ? S_RD : S_WR;
        end
      end
    end
  end

  assign mem_req_o   = (state_q == S_RD) || (state_q == S_WR);
  assign mem_we_o    = (state_q == S_WR);
  assign mem_wide_o  = wide_q;
  assign mem_addr_o  = (state_q == S_WR) ? dst_q : src_q;
  assign mem_wdata_o = hold_q;

  assign busy_o      = (state_q != S_IDLE);
  assign unit_done_o = unit_done_q;
  assign blk_done_o  = (state_q == S_FIN);
  assign irq_o       = blk_done_o && irq_en_q;
  assign en_clr_o    = blk_done_o && (!rep_q || timing_e'(tim_q) == TIM_NOW ||
                       (chan_q == 2'd3 && timing_e'(tim_q) == TIM_SPECIAL && last_line_i));
  assign src_o       = src_q;
  assign dst_o       = dst_q;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_wide_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ready_i,
  input logic              busy_o,
  input logic              blk_done_o,
  input logic              irq_o,
  input logic              en_clr_o
);
  a_r11_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r9_blk_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done_o |=> !blk_done_o);

  a_r7_irq_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> blk_done_o);

  a_r6_clr_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_o |-> blk_done_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  a_r4_no_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> mem_addr_o != '0);

  a_r10_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_wide_o ? mem_addr_o[1:0] == 2'b00 : mem_addr_o[0] == 1'b0));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_wide_o  (mem_wide_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i),
  .busy_o      (busy_o),
  .blk_done_o  (blk_done_o),
  .irq_o       (irq_o),
  .en_clr_o    (en_clr_o)
);

// File: tb/tb_dma_xfer_engine.sv
`timescale 1ns/1ps
module tb_dma_xfer_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         start = 0, wide = 0, rep = 0, irq_en = 0, last_line = 0;
  logic [1:0]   chan = 0, smode = 0, dmode = 0, tim = 0;
  logic [27:0]  src = 0, dst = 0;
  logic [16:0]  count = 0;
  logic [255:0] ws_tbl;
  logic         mem_req, mem_we, mem_wide, mem_ready;
  logic [27:0]  mem_addr, src_o, dst_o;
  logic [31:0]  mem_wdata, mem_rdata;
  logic         busy, unit_done, blk_done, irq_o, en_clr;

  logic stall_en = 0, rdy_rand = 1;
  int   n_chk = 0, n_fail = 0;
  int   wr_n = 0, rd_n = 0, ud_n = 0;
  logic [27:0] wr_addr [64];
  logic [31:0] wr_data [64];
  logic [31:0] exp_hold = 0;
  bit   finished = 0;

  function automatic logic [31:0] fdata(logic [27:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h1111};
  endfunction

  assign mem_rdata = fdata(mem_addr);
  assign mem_ready = !stall_en || rdy_rand;

  dma_xfer_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan),
    .src_i(src), .dst_i(dst), .count_i(count), .wide_i(wide),
    .src_mode_i(smode), .dst_mode_i(dmode), .repeat_i(rep), .timing_i(tim),
    .irq_en_i(irq_en), .last_line_i(last_line), .ws_tbl_i(ws_tbl),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wide_o(mem_wide),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready), .busy_o(busy), .unit_done_o(unit_done),
    .blk_done_o(blk_done), .irq_o(irq_o), .en_clr_o(en_clr),
    .src_o(src_o), .dst_o(dst_o)
  );

  always @(posedge clk) begin
    #2;
    rdy_rand = 1'($urandom % 2);
  end

  always @(negedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        if (wr_n < 64) begin
          wr_addr[wr_n] = mem_addr;
          wr_data[wr_n] = mem_wdata;
        end
        wr_n++;
      end else rd_n++;
    end
    if (unit_done) ud_n++;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ws_of(logic seq, logic w, logic [3:0] r);
    return ws_tbl[((int'(seq) * 2 + int'(w)) * 16 + int'(r)) * 4 +: 4];
  endfunction

  function automatic logic [27:0] bstep(logic [27:0] a, logic [1:0] m, logic w);
    logic [27:0] sz = w ? 28'd4 : 28'd2;
    case (m)
      2'd1:    return a - sz;
      2'd2:    return a;
      default: return a + sz;
    endcase
  endfunction

  task automatic run_block(input logic [1:0] ch, input logic [27:0] s, input logic [27:0] d,
                           input int cnt, input logic w, input logic [1:0] sm, input logic [1:0] dm,
                           input logic rp, input logic [1:0] tm, input logic ie, input logic ll,
                           input logic stl);
    logic [27:0] cs, cd, da;
    logic [27:0] ea [64];
    logic [31:0] ed [64];
    int cyc = 0, erd = 0, n;
    logic low = 0, eclr;
    cs = w ? {s[27:2], 2'b00} : {s[27:1], 1'b0};
    da = w ? {d[27:2], 2'b00} : {d[27:1], 1'b0};
    cd = da;
    for (int i = 0; i < cnt; i++) begin
      if (cs != 0) begin
        exp_hold = w ? fdata(cs) : {2{fdata(cs)[15:0]}};
        erd++;
      end
      ea[i] = cd;
      ed[i] = exp_hold;
      cyc += 2 + int'(ws_of(i != 0, w, cs[27:24])) + int'(ws_of(i != 0, w, cd[27:24]));
      low = (cs[27:24] < 4'd8) || (cd[27:24] < 4'd8);
      cs  = (cs == 0) ? cs : bstep(cs, sm, w);
      cd  = bstep(cd, dm, w);
    end
    if (low) cyc += 2;
    if (dm == 2'd3) cd = da;
    eclr = !rp || tm == 2'd0 || (ch == 2'd3 && tm == 2'd3 && ll);

    wr_n = 0; rd_n = 0; ud_n = 0; stall_en = stl;
    chan = ch; src = s; dst = d; count = 17'(cnt); wide = w; smode = sm; dmode = dm;
    rep = rp; tim = tm; irq_en = ie; last_line = ll; start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!blk_done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!stl) chk(n == cyc, "R3 R8 block cycles", n, cyc);
    chk(irq_o == ie, "R7 interrupt pulse", irq_o, ie);
    chk(en_clr == eclr, "R6 enable clear", en_clr, eclr);
    chk(dst_o == cd, "R7 R2 final destination", dst_o, cd);
    chk(src_o == cs, "R4 R2 final source", src_o, cs);
    @(negedge clk);
    chk(!blk_done, "R9 done lasts one cycle", blk_done, 0);
    chk(ud_n == cnt, "R9 unit pulses", ud_n, cnt);
    chk(rd_n == erd, "R4 read count", rd_n, erd);
    chk(wr_n == cnt, "R2 write count", wr_n, cnt);
    for (int i = 0; i < cnt && i < wr_n && i < 64; i++) begin
      chk(wr_addr[i] == ea[i], "R2 R10 write address", wr_addr[i], ea[i]);
      chk(wr_data[i] == ed[i], "R4 R5 write data", wr_data[i], ed[i]);
    end
    stall_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) ws_tbl[i*4 +: 4] = 4'($urandom % 4);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!mem_req, "R1 no request in reset", mem_req, 0);
    chk(!busy && !blk_done && !irq_o && !en_clr && !unit_done, "R1 quiet outputs", busy, 0);
    chk(src_o == 0 && dst_o == 0, "R1 pointers zero", dst_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1 idle after reset", busy, 0);

    // R1 R4: zero source first -> zeros written
    run_block(2'd0, 28'h0, 28'h3000100, 3, 1'b1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    // R5 R2: 16-bit, decrementing dest, cart regions, no tail
    run_block(2'd1, 28'h8000010, 28'h9000020, 4, 1'b0, 2'd0, 2'd1, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0);
    // R8: low source region with fixed source
    run_block(2'd2, 28'h2000040, 28'h8000000, 3, 1'b1, 2'd2, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0);
    // R7: reload mode, repeat kept
    run_block(2'd1, 28'h9000000, 28'h6000200, 5, 1'b1, 2'd3, 2'd3, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
    // R6: channel 3 special timing on last line / not
    run_block(2'd3, 28'h8000100, 28'h5000000, 2, 1'b0, 2'd0, 2'd2, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0);
    run_block(2'd3, 28'h8000100, 28'h5000000, 2, 1'b0, 2'd0, 2'd2, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
    // R10: misaligned start pointers
    run_block(2'd0, 28'h2000003, 28'h3000007, 2, 1'b1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    run_block(2'd0, 28'h2000003, 28'h3000007, 2, 1'b0, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    // R4: zero source replays last data
    run_block(2'd2, 28'h0, 28'h9000010, 3, 1'b1, 2'd0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    // R11: stalled port
    run_block(2'd1, 28'h4000020, 28'h8000040, 6, 1'b1, 2'd0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1);
    run_block(2'd2, 28'h0, 28'h3000040, 3, 1'b0, 2'd0, 2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1);

    for (int k = 0; k < 30; k++) begin
      logic [27:0] rs, rd;
      rs = {4'($urandom % 12), 12'h0, 12'($urandom)};
      if ($urandom % 8 == 0) rs = 0;
      rd = {4'($urandom % 12), 12'h0, 12'($urandom)};
      run_block(2'($urandom), rs, rd, 1 + int'($urandom % 10), 1'($urandom), 2'($urandom),
                2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom % 4 == 0));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule